// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Core

This block is a small processor built around one accumulator register. It fetches a 16-bit instruction word from a unified, word-addressed memory at the program counter. It then executes that word against the same memory. Only three operations touch data: copy a memory word into the accumulator, copy the accumulator into a memory word, and add a memory word into the accumulator. A fourth code stops the core. Every remaining code passes through without effect.

The memory sits outside the block and has a single synchronous port with a one-cycle read latency. As a result, the fetch phase and the execute phase each take two clock cycles, and every instruction takes four. After reset the core waits in an idle state until `start` is sampled high. It then runs from address 0 until it decodes a stop instruction, and from that point it holds `halted` high until the next reset.

Top module: `acc_core`

## Requirements
- R1: After reset, `halted` and `mem_we` are low, the program counter is 0 and the accumulator is 0, so the first instruction comes from address 0 and a store executed first writes 0.
- R2: While idle after reset with `start` low, the core writes no memory and `halted` stays low.
- R3: Each instruction is a two-cycle fetch phase followed by a two-cycle execute phase. The program counter steps by one after each fetch. A run of N instructions, the last being the stop code, raises `halted` 4N-1 clock edges after the edge that samples `start`.
- R4: Opcode 1 loads the accumulator with the memory word at the operand address.
- R5: Opcode 2 writes the accumulator to the operand address with a `mem_we` pulse exactly one cycle long. Each executed store produces one write and nothing else does.
- R6: Opcode 5 adds the word at the operand address to the accumulator, and the sum wraps modulo 2^16.
- R7: Opcode 0 stops the core: `halted` rises and stays high, and no further instruction runs or writes until reset.
- R8: Opcodes 3, 4 and 6 to 15 change neither the accumulator nor memory.
- R9: An instruction carries its opcode in bits 15:12 and its 12-bit operand address in bits 11:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Leaves the idle state when sampled high |
| mem_addr | output | ADDR_W (12) | Memory word address |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The bench builds the core with its defaults: a 12-bit address field and a 4-bit opcode, which gives a 4096-word memory model. That address range holds the 940/941 load-add-store program and the all-ones address 0xFFF used for the field-position check. It also leaves room for a separate 16-word data region at 0x800 that random programs read and write. Random programs there mix loads, adds, stores and every unused opcode against a bench interpreter, so the comparison covers accumulator carry-over between instructions, wrapping sums and exact run lengths.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Operation codes; values matter because the decoder compares against them.
  localparam logic [3:0] OPC_STOP  = 4'd0;
  localparam logic [3:0] OPC_LOAD  = 4'd1;
  localparam logic [3:0] OPC_STORE = 4'd2;
  localparam logic [3:0] OPC_ADD   = 4'd5;

  // Phase sequence of one instruction.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH_REQ,
    PH_FETCH_WAIT,
    PH_EXEC_REQ,
    PH_EXEC_DONE,
    PH_STOPPED
  } phase_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 4,
  localparam int WORD_W = OPC_W + ADDR_W
) (
  input  logic [WORD_W-1:0] ir,
  output logic [ADDR_W-1:0] oper_addr,
  output logic              is_load,
  output logic              is_store,
  output logic              is_add,
  output logic              is_stop
);

  logic [OPC_W-1:0] opc;

  // Opcode occupies the top field, operand address the low field.
  assign opc       = ir[WORD_W-1 -: OPC_W];
  assign oper_addr = ir[ADDR_W-1:0];

  assign is_load  = (opc == OPC_W'(OPC_LOAD));
  assign is_store = (opc == OPC_W'(OPC_STORE));
  assign is_add   = (opc == OPC_W'(OPC_ADD));
  assign is_stop  = (opc == OPC_W'(OPC_STOP));

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_stop,
  output logic fetch_req,
  output logic fetch_done,
  output logic exec_req,
  output logic exec_done,
  output logic halted
);

  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:       if (start) ph_d = PH_FETCH_REQ;
      PH_FETCH_REQ:  ph_d = PH_FETCH_WAIT;
      PH_FETCH_WAIT: ph_d = PH_EXEC_REQ;
      PH_EXEC_REQ:   ph_d = is_stop ? PH_STOPPED : PH_EXEC_DONE;
      PH_EXEC_DONE:  ph_d = PH_FETCH_REQ;
      PH_STOPPED:    ph_d = PH_STOPPED;
      default:       ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  // Named phase events shared with the datapath and the assertions.
  assign fetch_req  = (ph_q == PH_FETCH_REQ);
  assign fetch_done = (ph_q == PH_FETCH_WAIT);
  assign exec_req   = (ph_q == PH_EXEC_REQ);
  assign exec_done  = (ph_q == PH_EXEC_DONE);
  assign halted     = (ph_q == PH_STOPPED);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R7

  AST_FETCH_LEADS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (exec_req && !fetch_req)); // R3

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 4,
  localparam int WORD_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic              fetch_done,
  input  logic              exec_req,
  input  logic              exec_done,
  input  logic              is_load,
  input  logic              is_store,
  input  logic              is_add,
  input  logic [ADDR_W-1:0] oper_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] ir,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we
);

  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] ir_q;
  logic              acc_take;
  logic              acc_sum_ev;

  // Wrapping sum: the carry out of the top bit is dropped.
  function automatic logic [WORD_W-1:0] acc_sum(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
    logic [WORD_W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    return wide[WORD_W-1:0];
  endfunction

  assign acc_take   = exec_done && is_load;
  assign acc_sum_ev = exec_done && is_add;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (fetch_done) begin
        ir_q <= mem_rdata;
        pc_q <= pc_q + 1'b1;
      end
      if (acc_take)        acc_q <= mem_rdata;
      else if (acc_sum_ev) acc_q <= acc_sum(acc_q, mem_rdata);
    end
  end

  assign ir        = ir_q;
  assign mem_addr  = fetch_req ? pc_q : oper_addr;
  assign mem_wdata = acc_q;
  assign mem_we    = exec_req && is_store;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (pc_q - $past(pc_q)) == ADDR_W'(1)); // R3

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_done |=> $stable(pc_q)); // R3

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && !is_load && !is_add) |=> $stable(acc_q)); // R8

  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sum_ev |=> (acc_q - $past(acc_q)) == $past(mem_rdata)); // R6

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_done |=> $stable(ir_q)); // R9

endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int ADDR_W = 12,
  parameter int OPC_W  = 4,
  localparam int WORD_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted
);

  logic              fetch_req, fetch_done, exec_req, exec_done;
  logic              is_load, is_store, is_add, is_stop;
  logic [ADDR_W-1:0] oper_addr;
  logic [WORD_W-1:0] ir;

  acc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_stop    (is_stop),
    .fetch_req  (fetch_req),
    .fetch_done (fetch_done),
    .exec_req   (exec_req),
    .exec_done  (exec_done),
    .halted     (halted)
  );

  acc_decode #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_dec (
    .ir        (ir),
    .oper_addr (oper_addr),
    .is_load   (is_load),
    .is_store  (is_store),
    .is_add    (is_add),
    .is_stop   (is_stop)
  );

  acc_datapath #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_req  (fetch_req),
    .fetch_done (fetch_done),
    .exec_req   (exec_req),
    .exec_done  (exec_done),
    .is_load    (is_load),
    .is_store   (is_store),
    .is_add     (is_add),
    .oper_addr  (oper_addr),
    .mem_rdata  (mem_rdata),
    .ir         (ir),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we)
  );

  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R5

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we); // R7

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int OPC_W  = 4;
  localparam int DW     = OPC_W + ADDR_W;
  localparam int MEM_N  = 1 << ADDR_W;
  localparam int DATA_BASE = 'h800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic              mem_we;
  logic [DW-1:0]     mem_rdata = '0;
  logic              halted;

  logic [DW-1:0] mem     [MEM_N];
  logic [DW-1:0] ref_mem [MEM_N];
  int wr_count = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .halted(halted)
  );

  // Memory model: synchronous, one-cycle read latency.
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [DW-1:0] enc(input int op, input int a);
    return {op[3:0], a[11:0]};
  endfunction

  function automatic logic [DW-1:0] ref_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    int unsigned s;
    s = int'(a) + int'(b);
    return DW'(s % (1 << DW));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic put(input int a, input logic [DW-1:0] w);
    mem[a] = w;
    ref_mem[a] = w;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = '0;
      ref_mem[i] = '0;
    end
  endtask

  task automatic hold_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk) rst_n = 1'b1;
  endtask

  // Interpreter: returns executed instruction count (stop included) and stores.
  task automatic ref_run(output int n_ins, output int n_st);
    int pc;
    logic [DW-1:0] acc;
    logic [DW-1:0] w;
    int op;
    int a;
    pc = 0; acc = '0; n_ins = 0; n_st = 0;
    for (int guard = 0; guard < 5000; guard++) begin
      w = ref_mem[pc];
      op = int'(w[15:12]);
      a = int'(w[11:0]);
      pc = (pc + 1) % MEM_N;
      n_ins++;
      if (op == 0) break;
      else if (op == 1) acc = ref_mem[a];
      else if (op == 2) begin ref_mem[a] = acc; n_st++; end
      else if (op == 5) acc = ref_add(acc, ref_mem[a]);
    end
  endtask

  // Pulses start, returns edges from the start edge until halted is seen.
  task automatic run_core(output int edges);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    edges = 0;
    while (!halted && edges < 20000) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
  endtask

  task automatic run_and_check(input string tag);
    int n_ins, n_st, edges, w0;
    ref_run(n_ins, n_st);
    w0 = wr_count;
    release_reset();
    run_core(edges);
    check(edges == 4*n_ins-1, "R3", {tag, " halt edge count"}, edges, 4*n_ins-1);
    check(wr_count - w0 == n_st, "R5", {tag, " write count"}, wr_count - w0, n_st);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int w0;
    int edges;
    void'($urandom(32'd1357));

    // Reset state and idle behaviour.
    clear_mem();
    hold_reset();
    release_reset();
    check(halted == 1'b0, "R1", "halted after reset", halted, 0);
    check(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
    w0 = wr_count;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(wr_count == w0, "R2", "idle writes", wr_count - w0, 0);
    check(halted == 1'b0, "R2", "idle halted", halted, 0);

    // Load 940, add 941, store back to 941.
    hold_reset();
    clear_mem();
    put(0, enc(1, 940)); put(1, enc(5, 941)); put(2, enc(2, 941)); put(3, enc(0, 0));
    put(940, 16'h1234); put(941, 16'h0F0F);
    run_and_check("940/941");
    check(mem[941] == 16'h2143, "R6", "941 sum", mem[941], 16'h2143);
    check(mem[940] == 16'h1234, "R4", "940 untouched", mem[940], 16'h1234);
    check(halted == 1'b1, "R7", "halted after stop", halted, 1);

    // Fresh accumulator is zero; wrapping adds.
    hold_reset();
    clear_mem();
    put(0, enc(2, 'h880));
    put(1, enc(1, 'h810)); put(2, enc(5, 'h811)); put(3, enc(2, 'h881));
    put(4, enc(1, 'h812)); put(5, enc(5, 'h812)); put(6, enc(2, 'h882));
    put(7, enc(0, 0));
    put('h880, 16'hAAAA);
    put('h810, 16'hFFFF); put('h811, 16'h0003); put('h812, 16'h8000);
    run_and_check("wrap");
    check(mem['h880] == 16'h0000, "R1", "first store after reset", mem['h880], 0);
    check(mem['h881] == 16'h0002, "R6", "FFFF+3 wrap", mem['h881], 2);
    check(mem['h882] == 16'h0000, "R6", "8000+8000 wrap", mem['h882], 0);

    // Unused opcodes, then stop with a store placed after it.
    hold_reset();
    clear_mem();
    put(0, enc(1, 'h900));
    put(1, enc(3, 'h901)); put(2, enc(4, 'h901)); put(3, enc(6, 'h901));
    put(4, enc(7, 'h901)); put(5, enc(15, 'h901));
    put(6, enc(2, 'h902)); put(7, enc(0, 0)); put(8, enc(2, 'h901));
    put('h900, 16'hBEEF); put('h901, 16'h5555);
    run_and_check("nop");
    check(mem['h902] == 16'hBEEF, "R8", "acc kept across unused codes", mem['h902], 16'hBEEF);
    check(mem['h901] == 16'h5555, "R8", "canary after unused codes", mem['h901], 16'h5555);
    w0 = wr_count;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b1, "R7", "halted sticky", halted, 1);
    check(wr_count == w0, "R7", "no writes after stop", wr_count - w0, 0);
    check(mem['h901] == 16'h5555, "R7", "post-stop store skipped", mem['h901], 16'h5555);

    // Field positions: all-ones address, opcode in the top nibble.
    hold_reset();
    clear_mem();
    put(0, enc(1, 'hFFF)); put(1, enc(2, 'h123)); put(2, enc(0, 0));
    put('hFFF, 16'hC3A5);
    run_and_check("fields");
    check(mem['h123] == 16'hC3A5, "R9", "load 0xFFF store 0x123", mem['h123], 16'hC3A5);
    check(mem['h023] == 16'h0000, "R9", "neighbour 0x023 clear", mem['h023], 0);

    // Random programs against the interpreter.
    for (int p = 0; p < 30; p++) begin
      int len;
      hold_reset();
      clear_mem();
      len = 3 + $urandom_range(0, 20);
      for (int i = 0; i < len; i++) begin
        int r, op, a;
        r = $urandom_range(0, 9);
        a = DATA_BASE + $urandom_range(0, 15);
        if (r < 3) op = 1;
        else if (r < 6) op = 5;
        else if (r < 8) op = 2;
        else begin
          op = $urandom_range(3, 15);
          if (op == 5) op = 4;
        end
        put(i, enc(op, a));
      end
      put(len, enc(0, 0));
      for (int d = 0; d < 16; d++) put(DATA_BASE + d, 16'($urandom()));
      run_and_check("random");
      for (int d = 0; d < 16; d++)
        check(mem[DATA_BASE+d] == ref_mem[DATA_BASE+d], "R4", "random data word (R5 R6 R8)",
              mem[DATA_BASE+d], ref_mem[DATA_BASE+d]);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule